// File: doc/BRIEF.md
# PCM Codec Control Register Unit

This block holds the mode setting and the power state of a telephony PCM codec. A serial control port, whose shifter and first-byte decode are handled elsewhere, presents the second byte of a two-byte write instruction together with a one-cycle strobe. The block stores that byte and decodes its fields into registered outputs: the master clock divider select, the companding law, the data timing, the loopback mode and the power-amplifier behaviour in power-down. A read strobe returns the stored byte unchanged.

A separate single-byte power command switches the codec between the powered-up and powered-down states. After power-up the PCM transmit output enable stays low until the second rising edge of the transmit frame sync, so the output leaves high impedance only once a full frame has been seen. In digital loopback the byte last written into the receive PCM register is presented as the transmit PCM byte in place of the encoder's byte.

Top module: `pcm_ctl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the stored mode byte, every decoded field, `ctl_rd_byte`, `ctl_rd_valid`, `powered`, `pcm_oe`, `tx_pcm_byte` and the receive holding byte become 0, so the law is mu-255 (code 00) and loopback is off.
- R2: One clock after a write strobe, `mclk_sel` equals bits 7:6 of the written byte (00 512 kHz, 01 1.536/1.544 MHz, 10 2.048 MHz, 11 4.096 MHz).
- R3: One clock after a write, `law_sel` is 00 (mu-255) when bit 5 is 0 whatever bit 4 is, 01 (A-law with even-bit inversion) for bits 5:4 = 10, and 10 (A-law without inversion) for 11.
- R4: One clock after a write, `nondelayed` equals bit 3 of the written byte (0 delayed timing, 1 non-delayed).
- R5: One clock after a write, `loop_sel` is 01 (digital) whenever bit 2 is 1, 10 (analog) for bits 2:1 = 01, and 00 (normal) for 00.
- R6: One clock after a write, `amp_off_pd` equals bit 0 of the written byte (1 disables the amplifier in power-down).
- R7: A read strobe makes `ctl_rd_valid` high for the next cycle with `ctl_rd_byte` equal to the stored byte as it was before that edge; `ctl_rd_byte` holds between reads.
- R8: A power command whose bit 1 is 1 is ignored; with bit 1 at 0, bit 7 = 1 powers up and bit 7 = 0 powers down, `powered` following one clock later. A power-up while already powered changes nothing.
- R9: After power-up, `pcm_oe` rises one clock after the clock that samples the second rising edge of `fs_tx` seen while powered (an edge sampled in the same cycle as the power-up command does not count); `pcm_oe` is never high while `powered` is low.
- R10: A power-down command clears `pcm_oe` and `powered` on the next clock and restarts the frame-sync count.
- R11: One clock after each edge, `tx_pcm_byte` equals the receive holding byte when `loop_sel` is digital and `enc_byte` otherwise; the holding byte takes `rx_pcm_byte` on each `rx_pcm_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the mode byte |
| ctl_wr_byte | input | 8 | Second byte of a write instruction |
| ctl_rd | input | 1 | Read strobe for the mode byte |
| ctl_rd_byte | output | 8 | Stored mode byte returned by a read |
| ctl_rd_valid | output | 1 | Read data valid, one cycle |
| pwr_cmd | input | 1 | Single-byte power command strobe |
| pwr_cmd_byte | input | 8 | Power command byte (bit 7 up/down, bit 1 must be 0) |
| fs_tx | input | 1 | Transmit frame sync |
| rx_pcm_wr | input | 1 | Receive PCM register write strobe |
| rx_pcm_byte | input | 8 | Receive PCM byte |
| enc_byte | input | 8 | Encoder output byte for normal transmit |
| mclk_sel | output | 2 | Master clock divider select |
| law_sel | output | 2 | Coding law: 00 mu-255, 01 A-law inverted, 10 A-law plain |
| nondelayed | output | 1 | 1 selects non-delayed data timing |
| loop_sel | output | 2 | Loopback: 00 normal, 01 digital, 10 analog |
| amp_off_pd | output | 1 | Power amplifier disabled in power-down |
| powered | output | 1 | Powered-up state |
| pcm_oe | output | 1 | PCM transmit output enable |
| tx_pcm_byte | output | 8 | Byte presented in the transmit slot |

## Verification
Every decoded field, the read data and the power state are due exactly one clock after the strobe that causes them, and the output enable is due one clock after the cycle in which the second frame-sync rising edge is sampled. The transmit byte follows its source with one register, so a receive write shows up in loopback two clocks after its strobe. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge with the same one-register delays, and compares every output against it at the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/pcm_ctl_pkg.sv
package pcm_ctl_pkg;
  localparam int CTL_W = 8;
  localparam int PCM_W = 8;

  // mode byte field positions
  localparam int CLK_HI  = 7;
  localparam int CLK_LO  = 6;
  localparam int LAW_SEL = 5;
  localparam int LAW_INV = 4;
  localparam int TIMING  = 3;
  localparam int LB_DIG  = 2;
  localparam int LB_ANA  = 1;
  localparam int AMP_BIT = 0;

  // power command field positions
  localparam int PWR_UP_BIT    = 7;
  localparam int PWR_GUARD_BIT = 1;

  typedef enum logic [1:0] {
    LAW_MU     = 2'b00,
    LAW_A_INV  = 2'b01,
    LAW_A_PLAIN = 2'b10
  } law_e;

  typedef enum logic [1:0] {
    LOOP_NONE = 2'b00,
    LOOP_DIG  = 2'b01,
    LOOP_ANA  = 2'b10
  } loop_e;
endpackage

// File: rtl/pcm_ctl_mode_reg.sv
module pcm_ctl_mode_reg
  import pcm_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wr_byte,
  input  logic             rd,
  output logic [CTL_W-1:0] rd_byte,
  output logic             rd_valid,
  output logic [1:0]       mclk_sel,
  output law_e             law,
  output logic             nondelayed,
  output loop_e            loop_mode,
  output logic             amp_off
);
  logic [CTL_W-1:0] stored_q;

  function automatic law_e law_of(input logic [CTL_W-1:0] b);
    if (!b[LAW_SEL])     return LAW_MU;
    else if (!b[LAW_INV]) return LAW_A_INV;
    else                 return LAW_A_PLAIN;
  endfunction

  function automatic loop_e loop_of(input logic [CTL_W-1:0] b);
    if (b[LB_DIG])      return LOOP_DIG;
    else if (b[LB_ANA]) return LOOP_ANA;
    else                return LOOP_NONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stored_q   <= '0;
      mclk_sel   <= '0;
      law        <= LAW_MU;
      nondelayed <= 1'b0;
      loop_mode  <= LOOP_NONE;
      amp_off    <= 1'b0;
    end else if (wr) begin
      stored_q   <= wr_byte;
      mclk_sel   <= wr_byte[CLK_HI:CLK_LO];
      law        <= law_of(wr_byte);
      nondelayed <= wr_byte[TIMING];
      loop_mode  <= loop_of(wr_byte);
      amp_off    <= wr_byte[AMP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_byte <= stored_q;
    end
  end
endmodule

// File: rtl/pcm_ctl_power.sv
module pcm_ctl_power
  import pcm_ctl_pkg::*;
#(
  parameter int FS_WAIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic [CTL_W-1:0] cmd_byte,
  input  logic             fs,
  output logic             powered,
  output logic             oe
);
  localparam int CW = $clog2(FS_WAIT + 1);

  logic          fs_q;
  logic          fs_rise;
  logic [CW-1:0] seen_q;
  logic          cmd_ok, go_up, go_down;

  assign fs_rise = fs && !fs_q;
  assign cmd_ok  = cmd && !cmd_byte[PWR_GUARD_BIT];
  assign go_up   = cmd_ok && cmd_byte[PWR_UP_BIT];
  assign go_down = cmd_ok && !cmd_byte[PWR_UP_BIT];

  always_ff @(posedge clk) begin
    if (rst) fs_q <= 1'b0;
    else     fs_q <= fs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      powered <= 1'b0;
      oe      <= 1'b0;
      seen_q  <= '0;
    end else if (go_down) begin
      powered <= 1'b0;
      oe      <= 1'b0;
      seen_q  <= '0;
    end else if (go_up && !powered) begin
      powered <= 1'b1;
      seen_q  <= '0;
    end else if (powered && !oe && fs_rise) begin
      if (seen_q == CW'(FS_WAIT - 1)) oe <= 1'b1;
      else                            seen_q <= seen_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_ctl_loop_mux.sv
module pcm_ctl_loop_mux
  import pcm_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  loop_e            loop_mode,
  input  logic             rx_wr,
  input  logic [PCM_W-1:0] rx_byte,
  input  logic [PCM_W-1:0] enc_byte,
  output logic [PCM_W-1:0] tx_byte
);
  logic [PCM_W-1:0] rx_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold_q <= '0;
      tx_byte   <= '0;
    end else begin
      if (rx_wr) rx_hold_q <= rx_byte;
      tx_byte <= (loop_mode == LOOP_DIG) ? rx_hold_q : enc_byte;
    end
  end
endmodule

// File: rtl/pcm_ctl_unit.sv
module pcm_ctl_unit
  import pcm_ctl_pkg::*;
#(
  parameter int FS_WAIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wr_byte,
  input  logic             ctl_rd,
  output logic [CTL_W-1:0] ctl_rd_byte,
  output logic             ctl_rd_valid,
  input  logic             pwr_cmd,
  input  logic [CTL_W-1:0] pwr_cmd_byte,
  input  logic             fs_tx,
  input  logic             rx_pcm_wr,
  input  logic [PCM_W-1:0] rx_pcm_byte,
  input  logic [PCM_W-1:0] enc_byte,
  output logic [1:0]       mclk_sel,
  output logic [1:0]       law_sel,
  output logic             nondelayed,
  output logic [1:0]       loop_sel,
  output logic             amp_off_pd,
  output logic             powered,
  output logic             pcm_oe,
  output logic [PCM_W-1:0] tx_pcm_byte
);
  law_e  law_w;
  loop_e loop_w;

  pcm_ctl_mode_reg mode_i (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wr_byte(ctl_wr_byte),
    .rd(ctl_rd), .rd_byte(ctl_rd_byte), .rd_valid(ctl_rd_valid),
    .mclk_sel(mclk_sel), .law(law_w), .nondelayed(nondelayed),
    .loop_mode(loop_w), .amp_off(amp_off_pd)
  );

  pcm_ctl_power #(.FS_WAIT(FS_WAIT)) pwr_i (
    .clk(clk), .rst(rst), .cmd(pwr_cmd), .cmd_byte(pwr_cmd_byte),
    .fs(fs_tx), .powered(powered), .oe(pcm_oe)
  );

  pcm_ctl_loop_mux mux_i (
    .clk(clk), .rst(rst), .loop_mode(loop_w), .rx_wr(rx_pcm_wr),
    .rx_byte(rx_pcm_byte), .enc_byte(enc_byte), .tx_byte(tx_pcm_byte)
  );

  assign law_sel  = law_w;
  assign loop_sel = loop_w;
endmodule

// File: rtl/pcm_ctl_unit_chk.sv
module pcm_ctl_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] ctl_wr_byte,
  input logic       ctl_rd,
  input logic [7:0] ctl_rd_byte,
  input logic       ctl_rd_valid,
  input logic       pwr_cmd,
  input logic [7:0] pwr_cmd_byte,
  input logic       rx_pcm_wr,
  input logic [7:0] rx_pcm_byte,
  input logic [1:0] mclk_sel,
  input logic [1:0] loop_sel,
  input logic       amp_off_pd,
  input logic       powered,
  input logic       pcm_oe,
  input logic [7:0] tx_pcm_byte
);
  a_r2_clk_field: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> mclk_sel == $past(ctl_wr_byte[7:6]));

  a_r5_digital_wins: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wr_byte[2]) |=> loop_sel == 2'b01);

  a_r6_amp_field: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> amp_off_pd == $past(ctl_wr_byte[0]));

  a_r7_read_valid: assert property (@(posedge clk) disable iff (rst)
    ctl_rd |=> ctl_rd_valid);

  a_r7_read_back: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr ##1 (ctl_rd && !ctl_wr)) |=> ctl_rd_byte == $past(ctl_wr_byte, 2));

  a_r8_guard_ignored: assert property (@(posedge clk) disable iff (rst)
    (pwr_cmd && pwr_cmd_byte[1]) |=> $stable(powered));

  a_r9_oe_needs_power: assert property (@(posedge clk) disable iff (rst)
    pcm_oe |-> powered);

  a_r10_down_clears: assert property (@(posedge clk) disable iff (rst)
    (pwr_cmd && !pwr_cmd_byte[1] && !pwr_cmd_byte[7]) |=> (!pcm_oe && !powered));

  a_r11_loop_path: assert property (@(posedge clk) disable iff (rst)
    (rx_pcm_wr ##1 (loop_sel == 2'b01)) |=> tx_pcm_byte == $past(rx_pcm_byte, 2));
endmodule

bind pcm_ctl_unit pcm_ctl_unit_chk chk_i (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wr_byte(ctl_wr_byte),
  .ctl_rd(ctl_rd), .ctl_rd_byte(ctl_rd_byte), .ctl_rd_valid(ctl_rd_valid),
  .pwr_cmd(pwr_cmd), .pwr_cmd_byte(pwr_cmd_byte),
  .rx_pcm_wr(rx_pcm_wr), .rx_pcm_byte(rx_pcm_byte),
  .mclk_sel(mclk_sel), .loop_sel(loop_sel), .amp_off_pd(amp_off_pd),
  .powered(powered), .pcm_oe(pcm_oe), .tx_pcm_byte(tx_pcm_byte)
);

// File: tb/pcm_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module pcm_ctl_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0, ctl_rd = 1'b0, pwr_cmd = 1'b0, fs_tx = 1'b0, rx_pcm_wr = 1'b0;
  logic [7:0] ctl_wr_byte = '0, pwr_cmd_byte = '0, rx_pcm_byte = '0, enc_byte = '0;
  logic [7:0] ctl_rd_byte, tx_pcm_byte;
  logic       ctl_rd_valid, nondelayed, amp_off_pd, powered, pcm_oe;
  logic [1:0] mclk_sel, law_sel, loop_sel;

  always #5 clk = ~clk;

  pcm_ctl_unit dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wr_byte(ctl_wr_byte),
    .ctl_rd(ctl_rd), .ctl_rd_byte(ctl_rd_byte), .ctl_rd_valid(ctl_rd_valid),
    .pwr_cmd(pwr_cmd), .pwr_cmd_byte(pwr_cmd_byte), .fs_tx(fs_tx),
    .rx_pcm_wr(rx_pcm_wr), .rx_pcm_byte(rx_pcm_byte), .enc_byte(enc_byte),
    .mclk_sel(mclk_sel), .law_sel(law_sel), .nondelayed(nondelayed),
    .loop_sel(loop_sel), .amp_off_pd(amp_off_pd), .powered(powered),
    .pcm_oe(pcm_oe), .tx_pcm_byte(tx_pcm_byte)
  );

  int total = 0, bad = 0, cycles = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_byte = 0, m_rd = 0, m_rx = 0, m_tx = 0;
  bit m_rdv = 0, m_pw = 0, m_oe = 0, m_fs_prev = 0;
  int m_edges = 0;

  function automatic int law_of(input logic [7:0] b);
    if (!b[5]) return 0;
    return b[4] ? 2 : 1;
  endfunction
  function automatic int loop_of(input logic [7:0] b);
    if (b[2]) return 1;
    return b[1] ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    bit rise;
    cycles++;
    if (rst) begin
      m_byte = 0; m_rd = 0; m_rx = 0; m_tx = 0;
      m_rdv = 0; m_pw = 0; m_oe = 0; m_fs_prev = 0; m_edges = 0;
    end else begin
      rise = fs_tx && !m_fs_prev;
      m_fs_prev = fs_tx;
      m_tx = (loop_of(m_byte) == 1) ? m_rx : enc_byte;
      if (rx_pcm_wr) m_rx = rx_pcm_byte;
      m_rdv = ctl_rd;
      if (ctl_rd) m_rd = m_byte;
      if (ctl_wr) m_byte = ctl_wr_byte;
      if (pwr_cmd && !pwr_cmd_byte[1] && !pwr_cmd_byte[7]) begin
        m_pw = 0; m_oe = 0; m_edges = 0;
      end else if (pwr_cmd && !pwr_cmd_byte[1] && pwr_cmd_byte[7] && !m_pw) begin
        m_pw = 1; m_edges = 0;
      end else if (m_pw && !m_oe && rise) begin
        m_edges++;
        if (m_edges == 2) m_oe = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R2 mclk_sel", mclk_sel, m_byte[7:6]);
      chk("R3 law_sel", law_sel, law_of(m_byte));
      chk("R4 nondelayed", nondelayed, m_byte[3]);
      chk("R5 loop_sel", loop_sel, loop_of(m_byte));
      chk("R6 amp_off_pd", amp_off_pd, m_byte[0]);
      chk("R7 rd_valid", ctl_rd_valid, m_rdv);
      chk("R7 rd_byte", ctl_rd_byte, m_rd);
      chk("R8 powered", powered, m_pw);
      chk("R9 pcm_oe", pcm_oe, m_oe);
      chk("R11 tx_pcm_byte", tx_pcm_byte, m_tx);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [7:0] b);
    ctl_wr = 1; ctl_wr_byte = b;
    @(negedge clk); ctl_wr = 0;
    ctl_rd = 1;
    @(negedge clk); ctl_rd = 0;
    @(negedge clk);
  endtask

  task automatic pcmd(input logic [7:0] b);
    pwr_cmd = 1; pwr_cmd_byte = b;
    @(negedge clk); pwr_cmd = 0;
  endtask

  task automatic fs_pulse(input int hi, input int lo);
    fs_tx = 1; idle(hi); fs_tx = 0; idle(lo);
  endtask

  initial begin
    rst = 1;
    idle(3);
    // R1 reset state, checked directly
    chk("R1 mclk_sel", mclk_sel, 0);
    chk("R1 law_sel", law_sel, 0);
    chk("R1 loop_sel", loop_sel, 0);
    chk("R1 powered", powered, 0);
    chk("R1 pcm_oe", pcm_oe, 0);
    chk("R1 tx_pcm_byte", tx_pcm_byte, 0);
    chk("R1 rd_valid", ctl_rd_valid, 0);
    rst = 0;
    cmp_on = 1;
    idle(2);

    // R2..R6 field decoding
    wr_mode(8'h00); wr_mode(8'h10); wr_mode(8'h20); wr_mode(8'h30);
    wr_mode(8'h40); wr_mode(8'h80); wr_mode(8'hC0); wr_mode(8'h08);
    wr_mode(8'h02); wr_mode(8'h04); wr_mode(8'h06); wr_mode(8'h01);
    wr_mode(8'hFF);
    chk("R5 digital priority on 0xFF", loop_sel, 1);
    chk("R3 A-law plain on 0xFF", law_sel, 2);

    // R7 same-cycle read and write returns old byte
    ctl_wr = 1; ctl_wr_byte = 8'h5A; ctl_rd = 1;
    @(negedge clk); ctl_wr = 0; ctl_rd = 0;
    chk("R7 old byte on same-cycle read", ctl_rd_byte, 8'hFF);
    idle(2);

    // R8 guarded command ignored, then power-up
    pcmd(8'h82);
    chk("R8 guard bit ignored", powered, 0);
    pcmd(8'h80);
    chk("R8 powered after up", powered, 1);
    // R9 wide frame-sync pulses count once each
    fs_pulse(3, 4);
    chk("R9 oe low after first edge", pcm_oe, 0);
    fs_pulse(3, 4);
    chk("R9 oe high after second edge", pcm_oe, 1);
    pcmd(8'h80);
    chk("R8 up while powered no change", pcm_oe, 1);
    // R10 power-down
    pcmd(8'h00);
    chk("R10 oe cleared", pcm_oe, 0);
    chk("R10 powered cleared", powered, 0);
    fs_pulse(1, 2); fs_pulse(1, 2);
    chk("R9 no oe while down", pcm_oe, 0);
    // R9 edge with the power-up command does not count
    fs_tx = 1; pcmd(8'h80); fs_tx = 0; idle(2);
    fs_pulse(1, 2);
    chk("R9 same-cycle edge ignored", pcm_oe, 0);
    fs_pulse(1, 2);
    chk("R9 oe after two later edges", pcm_oe, 1);

    // R11 digital loopback
    wr_mode(8'h04);
    for (int i = 0; i < 8; i++) begin
      rx_pcm_wr = 1; rx_pcm_byte = 8'(8'h11 * i + 3); enc_byte = 8'(8'hA0 + i);
      @(negedge clk); rx_pcm_wr = 0;
      @(negedge clk);
      chk("R11 loopback byte", tx_pcm_byte, 8'(8'h11 * i + 3));
    end
    wr_mode(8'h02);
    enc_byte = 8'h3C; idle(2);
    chk("R11 encoder byte in analog loop", tx_pcm_byte, 8'h3C);

    // mixed stimulus compared by the model every cycle
    for (int i = 0; i < 3000; i++) begin
      ctl_wr = ($urandom % 6) == 0; ctl_wr_byte = 8'($urandom);
      ctl_rd = ($urandom % 4) == 0;
      pwr_cmd = ($urandom % 40) == 0; pwr_cmd_byte = 8'($urandom);
      fs_tx = ($urandom % 5) == 0;
      rx_pcm_wr = ($urandom % 3) == 0; rx_pcm_byte = 8'($urandom);
      enc_byte = 8'($urandom);
      @(negedge clk);
    end
    ctl_wr = 0; ctl_rd = 0; pwr_cmd = 0; fs_tx = 0; rx_pcm_wr = 0;
    idle(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule